// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator

This block holds two 40-bit signed accumulators, called A and B, which share one 40-bit adder/subtracter. On each accepted operation, one accumulator is both the source and the destination. The other adder input is an external 40-bit addend, taken either as is or complemented.

A load operation replaces the accumulator on the source side with zero. Combined with the complement path, this gives load, add, subtract and load-negated. The result is written back one clock after the operation is presented.

Each accumulator has its own saturation enable. One shared mode input places the saturation point either at the 32-bit signed boundary or at the full 40-bit boundary.

The block keeps status flags for each accumulator:
- an overflow flag, rewritten on every operation that touches that accumulator, which reports that the eight guard bits above bit 31 no longer agree;
- a sticky saturation flag, which records saturation or, with saturation off, a wrap of the sign bit.

Two single-cycle trap request outputs let an interrupt controller act on the overflow and the sign-wrap events.

Top module: `dual_sat_acc`

## Requirements
- R1: After reset, both accumulators, all four flags, both OR outputs and both trap outputs are zero.
- R2: With op_zero_src_i = 0, the selected accumulator becomes acc + addend (op_negate_i = 0) or acc - addend (op_negate_i = 1). The new value is visible after the next rising clock edge, while no saturation applies.
- R3: With op_zero_src_i = 1, the selected accumulator becomes the addend (op_negate_i = 0) or its two's complement negation (op_negate_i = 1).
- R4: op_slot_i = 0 selects A and op_slot_i = 1 selects B. The accumulator and overflow flag of the accumulator not selected keep their values.
- R5: The overflow flag of the selected accumulator is set when bits 39..32 of the unsaturated 40-bit result are not all equal, and is cleared otherwise. ov_any_o is the OR of both overflow flags.
- R6: With saturation disabled for the selected accumulator (sat_en_i[0] for A, sat_en_i[1] for B), the result wraps modulo 2^40. If the true sum leaves the 40-bit signed range, that accumulator's saturation flag is set.
- R7: With saturation enabled and sat_wide_i = 1, a true sum outside the 40-bit signed range writes 0x7FFFFFFFFF (positive) or 0x8000000000 (negative) and sets the saturation flag.
- R8: With saturation enabled and sat_wide_i = 0, a true sum outside the 32-bit signed range writes 0x007FFFFFFF or 0xFF80000000 and sets the saturation flag.
- R9: The saturation flags stay set until a cycle with sat_clr_i = 1, which clears both. If an operation in that same cycle sets a flag, that flag ends up set. sat_any_o is the OR of both saturation flags.
- R10: ov_trap_o is high for exactly the cycle after an operation whose overflow result is 1 while the enable bit of ov_trap_en_i for that accumulator is 1.
- R11: cat_trap_o is high for exactly the cycle after an operation that wraps the sign bit on an accumulator whose saturation is disabled, while cat_trap_en_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation accepted this cycle |
| op_slot_i | input | 1 | Accumulator select: 0 = A, 1 = B |
| op_zero_src_i | input | 1 | Use zero instead of the accumulator as source (load) |
| op_negate_i | input | 1 | Complement the addend with carry-in 1 (subtract) |
| addend_i | input | 40 | Addend, two's complement |
| sat_en_i | input | 2 | Saturation enable, bit 0 for A, bit 1 for B |
| sat_wide_i | input | 1 | 1 = saturate at 40 bits, 0 = at 32 bits |
| ov_trap_en_i | input | 2 | Overflow trap enable, bit 0 for A, bit 1 for B |
| cat_trap_en_i | input | 1 | Sign-wrap trap enable |
| sat_clr_i | input | 1 | Clear both saturation flags |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ov_a_o | output | 1 | Guard-bit overflow flag of A |
| ov_b_o | output | 1 | Guard-bit overflow flag of B |
| sat_a_o | output | 1 | Sticky saturation flag of A |
| sat_b_o | output | 1 | Sticky saturation flag of B |
| ov_any_o | output | 1 | OR of both overflow flags |
| sat_any_o | output | 1 | OR of both saturation flags |
| ov_trap_o | output | 1 | Overflow trap request pulse |
| cat_trap_o | output | 1 | Sign-wrap trap request pulse |

## Verification
The assertions assume several things about the inputs:
- op_slot_i, sat_en_i and sat_wide_i are known and steady in every cycle where op_valid_i is high.
- The saturation flags fall only because sat_clr_i was seen in the previous cycle.
- The mode inputs are sampled in the same cycle as the operation.

The stimulus changes every input only at the falling clock edge. It keeps op_valid_i low in reset, and alters the saturation and trap configuration only between operations. It sweeps every configuration against boundary addends at the 32-, 33- and 40-bit signed limits, so that accumulations cross each threshold from both directions.

// File: rtl/dsat_pkg.sv
package dsat_pkg;

    localparam int unsigned NUM_ACC = 2;

    typedef struct packed {
        logic zero_src;
        logic negate;
    } acc_op_t;

endpackage

// File: rtl/dsat_adder.sv
module dsat_adder
    import dsat_pkg::*;
#(
    parameter int unsigned W = 40
) (
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] addend_i,
    input  acc_op_t      op_i,
    output logic [W:0]   sum_o
);

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;

    always_comb begin
        lhs   = op_i.zero_src ? '0 : src_i;
        rhs   = op_i.negate ? ~addend_i : addend_i;
        sum_o = {lhs[W-1], lhs} + {rhs[W-1], rhs} + {{W{1'b0}}, op_i.negate};
    end

endmodule

// File: rtl/dsat_limit.sv
module dsat_limit #(
    parameter int unsigned W = 40,
    parameter int unsigned G = 8
) (
    input  logic [W:0]   sum_i,
    input  logic         sat_en_i,
    input  logic         wide_i,
    output logic [W-1:0] result_o,
    output logic         guard_ov_o,
    output logic         cat_ov_o,
    output logic         sat_hit_o
);

    localparam int unsigned LOW_W = W - G;
    localparam logic [W-1:0] WIDE_MAX   = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] WIDE_MIN   = ~WIDE_MAX;
    localparam logic [W-1:0] NARROW_MAX = {{(G+1){1'b0}}, {(LOW_W-1){1'b1}}};
    localparam logic [W-1:0] NARROW_MIN = ~NARROW_MAX;

    logic [G-1:0] guard;
    logic [G+1:0] upper;
    logic         narrow_out;
    logic         neg;

    always_comb begin
        guard      = sum_i[W-1:LOW_W];
        upper      = sum_i[W:LOW_W-1];
        guard_ov_o = ~((&guard) | ~(|guard));
        cat_ov_o   = sum_i[W] ^ sum_i[W-1];
        narrow_out = ~((&upper) | ~(|upper));
        neg        = sum_i[W];
        result_o   = sum_i[W-1:0];
        sat_hit_o  = 1'b0;
        if (sat_en_i) begin
            if (wide_i) begin
                if (cat_ov_o) begin
                    sat_hit_o = 1'b1;
                    result_o  = neg ? WIDE_MIN : WIDE_MAX;
                end
            end else if (narrow_out) begin
                sat_hit_o = 1'b1;
                result_o  = neg ? NARROW_MIN : NARROW_MAX;
            end
        end
    end

endmodule

// File: rtl/dual_sat_acc.sv
module dual_sat_acc
    import dsat_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic             op_slot_i,
    input  logic             op_zero_src_i,
    input  logic             op_negate_i,
    input  logic [ACC_W-1:0] addend_i,
    input  logic [1:0]       sat_en_i,
    input  logic             sat_wide_i,
    input  logic [1:0]       ov_trap_en_i,
    input  logic             cat_trap_en_i,
    input  logic             sat_clr_i,
    output logic [ACC_W-1:0] acc_a_o,
    output logic [ACC_W-1:0] acc_b_o,
    output logic             ov_a_o,
    output logic             ov_b_o,
    output logic             sat_a_o,
    output logic             sat_b_o,
    output logic             ov_any_o,
    output logic             sat_any_o,
    output logic             ov_trap_o,
    output logic             cat_trap_o
);

    typedef struct packed {
        logic [NUM_ACC-1:0][ACC_W-1:0] acc;
        logic [NUM_ACC-1:0]            ov;
        logic [NUM_ACC-1:0]            sat;
        logic                          ov_trap;
        logic                          cat_trap;
    } state_t;

    state_t          st_d, st_q;
    acc_op_t         op;
    logic [ACC_W-1:0] src_acc;
    logic [ACC_W:0]   true_sum;
    logic [ACC_W-1:0] lim_result;
    logic             guard_ov, cat_ov, sat_hit, slot_sat_en;

    assign op          = '{zero_src: op_zero_src_i, negate: op_negate_i};
    assign src_acc     = st_q.acc[op_slot_i];
    assign slot_sat_en = sat_en_i[op_slot_i];

    dsat_adder #(.W(ACC_W)) u_adder (
        .src_i    (src_acc),
        .addend_i (addend_i),
        .op_i     (op),
        .sum_o    (true_sum)
    );

    dsat_limit #(.W(ACC_W), .G(GUARD_W)) u_limit (
        .sum_i      (true_sum),
        .sat_en_i   (slot_sat_en),
        .wide_i     (sat_wide_i),
        .result_o   (lim_result),
        .guard_ov_o (guard_ov),
        .cat_ov_o   (cat_ov),
        .sat_hit_o  (sat_hit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ov_trap  = 1'b0;
        st_d.cat_trap = 1'b0;
        if (sat_clr_i) begin
            st_d.sat = '0;
        end
        if (op_valid_i) begin
            st_d.acc[op_slot_i] = lim_result;
            st_d.ov[op_slot_i]  = guard_ov;
            if (sat_hit || (!slot_sat_en && cat_ov)) begin
                st_d.sat[op_slot_i] = 1'b1;
            end
            st_d.ov_trap  = guard_ov && ov_trap_en_i[op_slot_i];
            st_d.cat_trap = cat_ov && !slot_sat_en && cat_trap_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_a_o    = st_q.acc[0];
    assign acc_b_o    = st_q.acc[1];
    assign ov_a_o     = st_q.ov[0];
    assign ov_b_o     = st_q.ov[1];
    assign sat_a_o    = st_q.sat[0];
    assign sat_b_o    = st_q.sat[1];
    assign ov_any_o   = |st_q.ov;
    assign sat_any_o  = |st_q.sat;
    assign ov_trap_o  = st_q.ov_trap;
    assign cat_trap_o = st_q.cat_trap;

endmodule

// File: rtl/dual_sat_acc_chk.sv
module dual_sat_acc_chk #(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid_i,
    input logic             op_slot_i,
    input logic [1:0]       sat_en_i,
    input logic             sat_wide_i,
    input logic             cat_trap_en_i,
    input logic             sat_clr_i,
    input logic [ACC_W-1:0] acc_a_o,
    input logic [ACC_W-1:0] acc_b_o,
    input logic             ov_a_o,
    input logic             ov_b_o,
    input logic             sat_a_o,
    input logic             sat_b_o,
    input logic             ov_trap_o,
    input logic             cat_trap_o
);

    localparam int unsigned LOW_W = ACC_W - GUARD_W;

    // R4
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_slot_i) |=> ($stable(acc_a_o) && $stable(ov_a_o)));

    // R4
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !op_slot_i) |=> ($stable(acc_b_o) && $stable(ov_b_o)));

    // R9
    sat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_a_o) |-> $past(op_valid_i && !op_slot_i));

    // R9
    sat_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sat_a_o) || $fell(sat_b_o)) |-> $past(sat_clr_i));

    // R8
    narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && !op_slot_i && sat_en_i[0] && !sat_wide_i)
        |=> ((&acc_a_o[ACC_W-1:LOW_W-1]) || !(|acc_a_o[ACC_W-1:LOW_W-1])));

    // R11
    cat_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cat_trap_o |-> $past(op_valid_i && cat_trap_en_i && !sat_en_i[op_slot_i]));

    // R10
    ov_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_trap_o |-> (ov_a_o || ov_b_o));

endmodule

bind dual_sat_acc dual_sat_acc_chk #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_chk (.*);

// File: tb/dual_sat_acc_bench.sv
module dual_sat_acc_bench;

    localparam int W = 40;
    localparam int G = 8;
    localparam int LW = W - G;

    localparam longint MAX40 = (longint'(1) << (W-1)) - 1;
    localparam longint MIN40 = -(longint'(1) << (W-1));
    localparam longint MAX32 = (longint'(1) << (LW-1)) - 1;
    localparam longint MIN32 = -(longint'(1) << (LW-1));
    localparam longint GMAX  = (longint'(1) << LW) - 1;
    localparam longint GMIN  = -(longint'(1) << LW);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_slot = 1'b0;
    logic         op_zero_src = 1'b0;
    logic         op_negate = 1'b0;
    logic [W-1:0] addend = '0;
    logic [1:0]   sat_en = '0;
    logic         sat_wide = 1'b0;
    logic [1:0]   ov_trap_en = '0;
    logic         cat_trap_en = 1'b0;
    logic         sat_clr = 1'b0;
    logic [W-1:0] acc_a, acc_b;
    logic         ov_a, ov_b, sat_a, sat_b, ov_any, sat_any, ov_trap, cat_trap;

    longint acc_m [2];
    bit     ov_m [2];
    bit     sat_m [2];
    bit     ovt_m, catt_m;
    int     n_vec = 0;
    int     n_bad = 0;
    bit     done = 1'b0;

    dual_sat_acc #(.ACC_W(W), .GUARD_W(G)) u_dual_sat_acc (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_slot_i(op_slot),
        .op_zero_src_i(op_zero_src), .op_negate_i(op_negate), .addend_i(addend),
        .sat_en_i(sat_en), .sat_wide_i(sat_wide), .ov_trap_en_i(ov_trap_en),
        .cat_trap_en_i(cat_trap_en), .sat_clr_i(sat_clr),
        .acc_a_o(acc_a), .acc_b_o(acc_b), .ov_a_o(ov_a), .ov_b_o(ov_b),
        .sat_a_o(sat_a), .sat_b_o(sat_b), .ov_any_o(ov_any), .sat_any_o(sat_any),
        .ov_trap_o(ov_trap), .cat_trap_o(cat_trap)
    );

    always #5 clk = ~clk;

    function automatic longint wrap(longint v);
        longint m;
        m = v & ((longint'(1) << W) - 1);
        if (m[W-1]) m = m - (longint'(1) << W);
        return m;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag0, string tag1);
        check(tag0, longint'($signed(acc_a)), acc_m[0]);
        check(tag1, longint'($signed(acc_b)), acc_m[1]);
        check("R5 ov_a", ov_a, ov_m[0]);
        check("R5 ov_b", ov_b, ov_m[1]);
        check("R5 ov_any", ov_any, ov_m[0] | ov_m[1]);
        check("R9 sat_a", sat_a, sat_m[0]);
        check("R9 sat_b", sat_b, sat_m[1]);
        check("R9 sat_any", sat_any, sat_m[0] | sat_m[1]);
        check("R10 ov_trap", ov_trap, ovt_m);
        check("R11 cat_trap", cat_trap, catt_m);
    endtask

    // called at a falling edge; returns at the falling edge after the result
    task automatic apply(int slot, bit zs, bit neg, longint addv, bit clr, string tag);
        longint src, d, tru, raw, res;
        bit     cat, ov, narrow, hit;
        string  t;
        op_valid    = 1'b1;
        op_slot     = slot[0];
        op_zero_src = zs;
        op_negate   = neg;
        addend      = addv[W-1:0];
        sat_clr     = clr;
        src    = zs ? 64'sd0 : acc_m[slot];
        d      = wrap(addv);
        tru    = neg ? src - d : src + d;
        cat    = (tru > MAX40) || (tru < MIN40);
        narrow = (tru > MAX32) || (tru < MIN32);
        raw    = wrap(tru);
        ov     = (raw > GMAX) || (raw < GMIN);
        res    = raw;
        hit    = 1'b0;
        t      = tag;
        if (sat_en[slot]) begin
            if (sat_wide) begin
                if (cat) begin hit = 1'b1; res = (tru < 0) ? MIN40 : MAX40; t = "R7"; end
            end else if (narrow) begin
                hit = 1'b1; res = (tru < 0) ? MIN32 : MAX32; t = "R8";
            end
        end else if (cat) begin
            t = "R6";
        end
        if (clr) begin sat_m[0] = 1'b0; sat_m[1] = 1'b0; end
        acc_m[slot] = res;
        ov_m[slot]  = ov;
        if (hit || (!sat_en[slot] && cat)) sat_m[slot] = 1'b1;
        ovt_m  = ov && ov_trap_en[slot];
        catt_m = cat && !sat_en[slot] && cat_trap_en;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        sat_clr  = 1'b0;
        if (slot == 0) compare_all(t, "R4 acc_b held");
        else           compare_all("R4 acc_a held", t);
    endtask

    task automatic idle_cycle(bit clr);
        sat_clr = clr;
        if (clr) begin sat_m[0] = 1'b0; sat_m[1] = 1'b0; end
        ovt_m  = 1'b0;
        catt_m = 1'b0;
        @(posedge clk);
        @(negedge clk);
        sat_clr = 1'b0;
        compare_all("R4 idle acc_a", "R4 idle acc_b");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        longint vals [12];
        vals = '{64'sd0, 64'sd1, -64'sd1, MAX32, MAX32 + 1, MIN32, GMAX, GMIN,
                 longint'(1) << (W-2), MAX40, MIN40, 64'sh12_3456_789A};
        acc_m[0] = 0; acc_m[1] = 0;
        ov_m[0] = 0; ov_m[1] = 0; sat_m[0] = 0; sat_m[1] = 0;
        ovt_m = 0; catt_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1 acc_a", "R1 acc_b");

        // R10 pulse lasts one cycle
        ov_trap_en = 2'b11;
        apply(0, 1'b1, 1'b0, longint'(1) << 35, 1'b0, "R3");
        idle_cycle(1'b0);
        // R11 and R9: sign wrap with saturation off, clear in the same cycle
        sat_en = 2'b00; cat_trap_en = 1'b1;
        apply(1, 1'b1, 1'b0, MAX40, 1'b0, "R3");
        apply(1, 1'b0, 1'b0, 64'sd1, 1'b1, "R6");
        idle_cycle(1'b0);
        idle_cycle(1'b1);

        for (int cfg = 0; cfg < 8; cfg++) begin
            sat_en      = cfg[1:0];
            sat_wide    = cfg[2];
            ov_trap_en  = {cfg[0], cfg[1]};
            cat_trap_en = cfg[2] ^ cfg[0];
            for (int vi = 0; vi < 12; vi++) begin
                for (int kind = 0; kind < 4; kind++) begin
                    for (int slot = 0; slot < 2; slot++) begin
                        apply(slot, (kind == 0) || (kind == 3), kind >= 2, vals[vi],
                              ((vi + kind) % 5) == 4,
                              ((kind == 0) || (kind == 3)) ? "R3" : "R2");
                    end
                end
            end
            idle_cycle(cfg[0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule